// File: doc/BRIEF.md
# Interleaved Memory Leaf Read Controller

This block is the read path of one leaf of a two-leaf, interleaved memory array. A read request names a 128-byte cache line by its line address. The block decides whether the line belongs to its leaf and which of its four banks holds it. It then asks the memory for its 64-byte half of the line and collects that half from a 256-bit memory data bus over two beats. Each 64-bit word comes with eight check bits and passes through a single-error-correcting, double-error-detecting decoder before it is stored in a line buffer.

Once both memory beats have arrived, the buffered half line goes out on a 128-bit system-bus slice over four consecutive beats. A line that maps to a bank marked faulty is never read from memory. It is answered with an error-flagged, all-zero burst. An uncorrectable word also flags the whole burst. Corrected words are counted in a saturating counter and signalled with a one-cycle pulse. Write traffic, DRAM timing and the partner leaf are outside this block, and a single clock drives everything.

Top module: `leaf_rd_ctrl`

## Requirements
- R1: When `interleave` is high, line address bit 0 selects the leaf. A request whose bit 0 differs from `leaf_id` is ignored: no `mem_req` is raised and no bus beat appears. When `interleave` is low, every request belongs to this leaf.
- R2: The bank index is line address bits [2:1] when interleaving and bits [1:0] otherwise. The row sent on `mem_row` is the line address shifted right by 3 or by 2 respectively. `mem_req` pulses for one cycle in the cycle after the request is accepted.
- R3: A request to a bank whose `bank_en` bit is 0 raises no `mem_req`. It is answered in the next cycle by four beats of all-zero data with `bus_err` high.
- R4: The memory returns two beats, and beat k carries words 4k to 4k+3, with word i at bits 64*(i mod 4). After the second memory beat, four bus beats follow in consecutive cycles. Bus beat b carries word 2b in bits [63:0] and word 2b+1 in bits [127:64], and `bus_last` is high on the fourth beat only.
- R5: Check bits use a Hamming layout over code positions 1..71. Data bits take the non-power-of-two positions in ascending order. Check bit i (i = 0..6) is the XOR of the data bits whose position has bit i set, and check bit 7 makes the parity of all 72 bits even. A single flipped data bit is corrected before it reaches the bus.
- R6: A single flipped check bit leaves the data unchanged and counts as a corrected error.
- R7: Two flipped bits in any word set `bus_err` on all four beats of that line.
- R8: `ce_count` rises by the number of corrected words in each memory beat and saturates at its maximum (15 by default). `ce_pulse` is high for one cycle after any memory beat that held a corrected word.
- R9: `req_ready` is high when the block is idle and during the fourth bus beat, and low otherwise. A request presented during the fourth beat is accepted, and its `mem_req` appears in the next cycle.
- R10: After reset, `req_ready` is high, and `bus_valid`, `mem_req`, `ce_pulse` and `ce_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| interleave | input | 1 | High when two leaves share the line space |
| leaf_id | input | 1 | Leaf number of this controller |
| bank_en | input | 4 | Per-bank enable, 0 marks a faulty bank |
| req_valid | input | 1 | Read request present |
| req_addr | input | 8 | Cache-line address |
| req_ready | output | 1 | Request can be accepted |
| mem_req | output | 1 | One-cycle memory read strobe |
| mem_bank | output | 2 | Bank addressed by the memory read |
| mem_row | output | 8 | Row part of the line address |
| mem_valid | input | 1 | Memory data beat present |
| mem_data | input | 256 | Four 64-bit words of one memory beat |
| mem_chk | input | 32 | Eight check bits per word |
| bus_valid | output | 1 | System-bus beat present |
| bus_data | output | 128 | Two corrected words per bus beat |
| bus_err | output | 1 | Line failed: disabled bank or uncorrectable word |
| bus_last | output | 1 | Fourth beat of the burst |
| ce_pulse | output | 1 | A corrected word was seen in the last memory beat |
| ce_count | output | 4 | Saturating count of corrected words |

## Verification
The bench sends lines that belong to the partner leaf. A design that ignored leaf selection would start a memory read for them. It uses banks picked out by both address slices, because a design with the bank bits off by one would address the wrong bank or refuse a healthy one. It flips data bits, check bits and bit pairs in chosen words: a decoder with a wrong position map would send corrupted data, miscount check-bit errors or miss double errors. It also holds a request open across the fourth beat and saturates the counter, which catches a controller that stalls for an extra cycle or whose count wraps to zero.

// File: rtl/leaf_rd_pkg.sv
package leaf_rd_pkg;

    localparam int WORD_W = 64;
    localparam int CHK_W  = 8;
    localparam int TOP_POS = 71;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_SEND = 2'd2
    } phase_e;

    // Seven Hamming bits: XOR of the code positions of all set data bits,
    // plus an eighth bit giving even parity over the whole codeword.
    function automatic logic [CHK_W-1:0] chk_gen(input logic [WORD_W-1:0] d);
        logic [6:0] h;
        int         j;
        h = '0;
        j = 0;
        for (int p = 1; p <= TOP_POS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[j]) h = h ^ 7'(p);
                j++;
            end
        end
        return {(^d) ^ (^h), h};
    endfunction

endpackage

// File: rtl/leaf_ecc_fix.sv
module leaf_ecc_fix
    import leaf_rd_pkg::*;
(
    input  logic [WORD_W-1:0] d_in,
    input  logic [CHK_W-1:0]  c_in,
    output logic [WORD_W-1:0] d_out,
    output logic              fixed,
    output logic              broken
);
    logic [CHK_W-1:0] regen;
    logic [6:0]       syn;
    logic             par;

    always_comb begin
        int j;
        regen  = chk_gen(d_in);
        syn    = regen[6:0] ^ c_in[6:0];
        par    = ^{d_in, c_in};
        d_out  = d_in;
        fixed  = 1'b0;
        broken = 1'b0;
        j      = 0;
        if (par) begin
            if (syn <= 7'(TOP_POS)) begin
                fixed = 1'b1;
                for (int p = 1; p <= TOP_POS; p++) begin
                    if ((p & (p - 1)) != 0) begin
                        if (7'(p) == syn) d_out[j] = ~d_in[j];
                        j++;
                    end
                end
            end else begin
                broken = 1'b1;
            end
        end else if (syn != 7'd0) begin
            broken = 1'b1;
        end
    end

endmodule

// File: rtl/leaf_line_map.sv
module leaf_line_map #(
    parameter int ADDR_W = 8,
    parameter int BANKS  = 4,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic [ADDR_W-1:0] line_addr,
    input  logic              interleave,
    input  logic              leaf_id,
    input  logic [BANKS-1:0]  bank_en,
    output logic              mine,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] row,
    output logic              bank_off
);
    always_comb begin
        if (interleave) begin
            mine = (line_addr[0] == leaf_id);
            bank = line_addr[BANK_W:1];
            row  = line_addr >> (BANK_W + 1);
        end else begin
            mine = 1'b1;
            bank = line_addr[BANK_W-1:0];
            row  = line_addr >> BANK_W;
        end
        bank_off = ~bank_en[bank];
    end

endmodule

// File: rtl/leaf_rd_ctrl.sv
module leaf_rd_ctrl
    import leaf_rd_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BANKS     = 4,
    parameter int MEM_W     = 256,
    parameter int BUS_W     = 128,
    parameter int MEM_BEATS = 2,
    parameter int CNT_W     = 4,
    localparam int BANK_W    = $clog2(BANKS),
    localparam int WPB       = MEM_W / WORD_W,
    localparam int BUF_W     = MEM_W * MEM_BEATS,
    localparam int BUS_BEATS = BUF_W / BUS_W,
    localparam int BEAT_W    = (BUS_BEATS > MEM_BEATS) ? $clog2(BUS_BEATS) : $clog2(MEM_BEATS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 interleave,
    input  logic                 leaf_id,
    input  logic [BANKS-1:0]     bank_en,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 req_ready,
    output logic                 mem_req,
    output logic [BANK_W-1:0]    mem_bank,
    output logic [ADDR_W-1:0]    mem_row,
    input  logic                 mem_valid,
    input  logic [MEM_W-1:0]     mem_data,
    input  logic [WPB*CHK_W-1:0] mem_chk,
    output logic                 bus_valid,
    output logic [BUS_W-1:0]     bus_data,
    output logic                 bus_err,
    output logic                 bus_last,
    output logic                 ce_pulse,
    output logic [CNT_W-1:0]     ce_count
);
    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    typedef struct packed {
        phase_e              ph;
        logic [BEAT_W-1:0]   beat;
        logic [BUF_W-1:0]    line;
        logic                err;
        logic                mreq;
        logic [BANK_W-1:0]   bank;
        logic [ADDR_W-1:0]   row;
        logic [CNT_W-1:0]    ce_cnt;
        logic                ce_pls;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              hit_mine, hit_off;
    logic [BANK_W-1:0] hit_bank;
    logic [ADDR_W-1:0] hit_row;
    logic [MEM_W-1:0]  fix_data;
    logic [WPB-1:0]    fix_v, bad_v;
    logic              accept;
    logic [CNT_W:0]    ce_sum;

    leaf_line_map #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_map (
        .line_addr (req_addr),
        .interleave(interleave),
        .leaf_id   (leaf_id),
        .bank_en   (bank_en),
        .mine      (hit_mine),
        .bank      (hit_bank),
        .row       (hit_row),
        .bank_off  (hit_off)
    );

    for (genvar g = 0; g < WPB; g++) begin : g_fix
        leaf_ecc_fix u_fix (
            .d_in  (mem_data[g*WORD_W +: WORD_W]),
            .c_in  (mem_chk[g*CHK_W +: CHK_W]),
            .d_out (fix_data[g*WORD_W +: WORD_W]),
            .fixed (fix_v[g]),
            .broken(bad_v[g])
        );
    end

    assign req_ready = (ctl_q.ph == PH_IDLE) ||
                       ((ctl_q.ph == PH_SEND) && (ctl_q.beat == BEAT_W'(BUS_BEATS - 1)));
    assign accept    = req_valid && req_ready && hit_mine;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.mreq   = 1'b0;
        ctl_d.ce_pls = 1'b0;
        ce_sum       = {1'b0, ctl_q.ce_cnt} + (CNT_W+1)'($countones(fix_v));
        case (ctl_q.ph)
            PH_FILL: begin
                if (mem_valid) begin
                    ctl_d.line[int'(ctl_q.beat)*MEM_W +: MEM_W] = fix_data;
                    ctl_d.err    = ctl_q.err | (|bad_v);
                    ctl_d.ce_pls = |fix_v;
                    ctl_d.ce_cnt = (ce_sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : ce_sum[CNT_W-1:0];
                    if (ctl_q.beat == BEAT_W'(MEM_BEATS - 1)) begin
                        ctl_d.ph   = PH_SEND;
                        ctl_d.beat = '0;
                    end else begin
                        ctl_d.beat = ctl_q.beat + 1'b1;
                    end
                end
            end
            PH_SEND: begin
                if (ctl_q.beat == BEAT_W'(BUS_BEATS - 1)) begin
                    ctl_d.ph   = PH_IDLE;
                    ctl_d.beat = '0;
                end else begin
                    ctl_d.beat = ctl_q.beat + 1'b1;
                end
            end
            default: ;
        endcase
        if (accept) begin
            ctl_d.beat = '0;
            ctl_d.bank = hit_bank;
            ctl_d.row  = hit_row;
            if (hit_off) begin
                ctl_d.ph   = PH_SEND;
                ctl_d.line = '0;
                ctl_d.err  = 1'b1;
            end else begin
                ctl_d.ph   = PH_FILL;
                ctl_d.err  = 1'b0;
                ctl_d.mreq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_req   = ctl_q.mreq;
    assign mem_bank  = ctl_q.bank;
    assign mem_row   = ctl_q.row;
    assign bus_valid = (ctl_q.ph == PH_SEND);
    assign bus_data  = ctl_q.line[int'(ctl_q.beat)*BUS_W +: BUS_W];
    assign bus_err   = bus_valid && ctl_q.err;
    assign bus_last  = bus_valid && (ctl_q.beat == BEAT_W'(BUS_BEATS - 1));
    assign ce_pulse  = ctl_q.ce_pls;
    assign ce_count  = ctl_q.ce_cnt;

    // R1: a line owned by the partner leaf never starts a memory read
    a_r1_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !hit_mine) |=> !mem_req);

    // R3: a faulty bank is answered at once with a flagged burst and no read
    a_r3_off_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hit_mine && hit_off) |=> (!mem_req && bus_valid && bus_err));

    // R4: the burst does not break before its last beat
    a_r4_burst_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_last) |=> bus_valid);

    // R4: nothing follows the last beat unless a new request came in
    a_r4_burst_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_last && !req_valid) |=> !bus_valid);

    // R8: the corrected-error count never goes down
    a_r8_count_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        ce_count >= $past(ce_count));

    // R9: no request is taken during the first three beats of a burst
    a_r9_busy_mid_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_last) |-> !req_ready);

endmodule

// File: tb/sim_leaf_rd_ctrl.sv
`timescale 1ns/1ps
module sim_leaf_rd_ctrl;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         interleave, leaf_id;
    logic [3:0]   bank_en;
    logic         req_valid;
    logic [7:0]   req_addr;
    logic         req_ready;
    logic         mem_req;
    logic [1:0]   mem_bank;
    logic [7:0]   mem_row;
    logic         mem_valid;
    logic [255:0] mem_data;
    logic [31:0]  mem_chk;
    logic         bus_valid;
    logic [127:0] bus_data;
    logic         bus_err, bus_last, ce_pulse;
    logic [3:0]   ce_count;

    int total = 0;
    int bad   = 0;
    int ce_tot = 0;

    logic [63:0] wd [8];
    logic [7:0]  wc [8];
    logic [63:0] good [8];

    always #4 clk = ~clk;

    leaf_rd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .interleave(interleave), .leaf_id(leaf_id),
        .bank_en(bank_en), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .mem_req(mem_req), .mem_bank(mem_bank),
        .mem_row(mem_row), .mem_valid(mem_valid), .mem_data(mem_data),
        .mem_chk(mem_chk), .bus_valid(bus_valid), .bus_data(bus_data),
        .bus_err(bus_err), .bus_last(bus_last), .ce_pulse(ce_pulse),
        .ce_count(ce_count)
    );

    // addr[22:15] il[14] leaf[13] en[12:9] kind[8:7] word[6:4] acc[3] err[2] bank[1:0]
    // kind: 0 clean, 1 one data bit, 2 one check bit, 3 two data bits
    localparam int NV = 8;
    localparam logic [22:0] VEC [NV] = '{
        {8'h10, 1'b0, 1'b0, 4'hF,    2'd0, 3'd0, 1'b1, 1'b0, 2'd0},
        {8'h23, 1'b1, 1'b1, 4'hF,    2'd1, 3'd5, 1'b1, 1'b0, 2'd1},
        {8'h22, 1'b1, 1'b1, 4'hF,    2'd0, 3'd0, 1'b0, 1'b0, 2'd1},
        {8'h36, 1'b0, 1'b0, 4'b1011, 2'd0, 3'd0, 1'b1, 1'b1, 2'd2},
        {8'h07, 1'b0, 1'b0, 4'hF,    2'd2, 3'd2, 1'b1, 1'b0, 2'd3},
        {8'h0D, 1'b1, 1'b1, 4'hF,    2'd3, 3'd0, 1'b1, 1'b1, 2'd2},
        {8'h44, 1'b1, 1'b0, 4'b1101, 2'd0, 3'd0, 1'b1, 1'b0, 2'd2},
        {8'h1B, 1'b1, 1'b1, 4'b1101, 2'd0, 3'd0, 1'b1, 1'b1, 2'd1}
    };

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // code position of data bit j: the (j+1)-th non-power-of-two
    function automatic int code_pos(input int j);
        int n = -1;
        for (int p = 3; p < 128; p++) begin
            if ((p & (p - 1)) != 0) begin
                n++;
                if (n == j) return p;
            end
        end
        return 0;
    endfunction

    function automatic logic [7:0] tb_chk(input logic [63:0] d);
        logic [7:0] c = '0;
        for (int i = 0; i < 7; i++)
            for (int j = 0; j < 64; j++)
                if (((code_pos(j) >> i) & 1) == 1) c[i] = c[i] ^ d[j];
        c[7] = ^{d, c[6:0]};
        return c;
    endfunction

    task automatic make_line(input logic [7:0] a, input logic [1:0] kind, input int w, input bit all);
        for (int i = 0; i < 8; i++) begin
            good[i] = {a, 8'(i), 48'h3C96_A51E_7F0B};
            wd[i]   = good[i];
            wc[i]   = tb_chk(good[i]);
            if (all || i == w) begin
                case (kind)
                    2'd1: wd[i][(i*7+3)%64] = ~wd[i][(i*7+3)%64];
                    2'd2: wc[i][3] = ~wc[i][3];
                    2'd3: begin wd[i][5] = ~wd[i][5]; wd[i][40] = ~wd[i][40]; end
                    default: ;
                endcase
            end
        end
    endtask

    task automatic put_beat(input int k);
        for (int i = 0; i < 4; i++) begin
            mem_data[64*i +: 64] = wd[4*k+i];
            mem_chk[8*i +: 8]    = wc[4*k+i];
        end
    endtask

    task automatic run_line(input logic [7:0] a, input logic il, input logic lf,
                            input logic [3:0] en, input logic [1:0] kind, input int w,
                            input bit all, input logic acc, input logic err,
                            input logic [1:0] bk);
        logic off = ~en[bk];
        int   nce = 0;
        logic p0, p1;
        logic [7:0] row = il ? (a >> 3) : (a >> 2);
        make_line(a, kind, w, all);
        if (acc && !off && (kind == 2'd1 || kind == 2'd2)) nce = all ? 8 : 1;
        @(negedge clk);
        interleave = il; leaf_id = lf; bank_en = en;
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (!acc) begin
            for (int c = 0; c < 3; c++) begin
                check("R1 foreign mem_req", 128'(mem_req), 128'd0);
                check("R1 foreign bus_valid", 128'(bus_valid), 128'd0);
                @(negedge clk);
            end
            return;
        end
        if (off) begin
            check("R3 no mem_req", 128'(mem_req), 128'd0);
        end else begin
            check("R2 mem_req", 128'(mem_req), 128'd1);
            check("R2 bank", 128'(mem_bank), 128'(bk));
            check("R2 row", 128'(mem_row), 128'(row));
            check("R9 busy while filling", 128'(req_ready), 128'd0);
            mem_valid = 1'b1; put_beat(0);
            @(negedge clk);
            p0 = ce_pulse;
            put_beat(1);
            @(negedge clk);
            p1 = ce_pulse;
            mem_valid = 1'b0;
            check("R8 pulse", 128'(p0 | p1), 128'(nce > 0));
        end
        for (int b = 0; b < 4; b++) begin
            check("R4 bus_valid", 128'(bus_valid), 128'd1);
            check("R4 bus_last", 128'(bus_last), 128'(b == 3));
            check("R9 ready in burst", 128'(req_ready), 128'(b == 3));
            if (off) begin
                check("R3 err", 128'(bus_err), 128'd1);
                check("R3 zero data", bus_data, 128'd0);
            end else if (err) begin
                check("R7 err", 128'(bus_err), 128'd1);
            end else begin
                check("R4 R5 R6 data", bus_data, {good[2*b+1], good[2*b]});
                check("R7 no err", 128'(bus_err), 128'd0);
            end
            @(negedge clk);
        end
        check("R4 burst over", 128'(bus_valid), 128'd0);
        ce_tot = (ce_tot + nce > 15) ? 15 : ce_tot + nce;
        check("R8 count", 128'(ce_count), 128'(ce_tot));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; interleave = 1'b0; leaf_id = 1'b0; bank_en = 4'hF;
        req_valid = 1'b0; req_addr = '0; mem_valid = 1'b0;
        mem_data = '0; mem_chk = '0;
        repeat (3) @(negedge clk);
        check("R10 ready", 128'(req_ready), 128'd1);
        check("R10 bus_valid", 128'(bus_valid), 128'd0);
        check("R10 mem_req", 128'(mem_req), 128'd0);
        check("R10 ce", 128'({ce_pulse, ce_count}), 128'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [22:0] e = VEC[v];
            run_line(e[22:15], e[14], e[13], e[12:9], e[8:7], int'(e[6:4]),
                     1'b0, e[3], e[2], e[1:0]);
        end

        // R8: every word carries one fixable error, twice: count saturates at 15
        run_line(8'h50, 1'b0, 1'b0, 4'hF, 2'd1, 0, 1'b1, 1'b1, 1'b0, 2'd0);
        run_line(8'h61, 1'b0, 1'b0, 4'hF, 2'd2, 0, 1'b1, 1'b1, 1'b0, 2'd1);
        check("R8 saturated", 128'(ce_count), 128'd15);

        // R9: a request held across the fourth beat is taken on that beat
        make_line(8'h10, 2'd0, 0, 1'b0);
        @(negedge clk);
        interleave = 1'b0; bank_en = 4'hF; req_valid = 1'b1; req_addr = 8'h10;
        @(negedge clk);
        req_valid = 1'b0;
        mem_valid = 1'b1; put_beat(0);
        @(negedge clk);
        put_beat(1);
        @(negedge clk);
        mem_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 last beat", 128'(bus_last), 128'd1);
        check("R9 ready on last", 128'(req_ready), 128'd1);
        req_valid = 1'b1; req_addr = 8'h05;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 back to back mem_req", 128'(mem_req), 128'd1);
        check("R9 back to back bank", 128'(mem_bank), 128'd1);
        check("R9 no beat while filling", 128'(bus_valid), 128'd0);
        make_line(8'h05, 2'd0, 0, 1'b0);
        mem_valid = 1'b1; put_beat(0);
        @(negedge clk);
        put_beat(1);
        @(negedge clk);
        mem_valid = 1'b0;
        check("R9 second line data", bus_data, {good[1], good[0]});
        repeat (4) @(negedge clk);
        check("R9 idle after", 128'(bus_valid), 128'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule